// File: doc/BRIEF.md
# Parity-Checked Channel Ingress Node

This block is one input lane of a multi-lane data formatter. A source upstream offers 32-bit words with a valid strobe and one parity bit per word. The node checks each word's parity. It stores correct words in a small internal FIFO and discards words whose parity fails. When a word is discarded, the node raises a one-cycle error pulse. The node applies backpressure through an active-high wait output. A word moves across the input on a rising clock edge where valid is high and wait is low. The sender keeps the word on the lines until it sees wait low.

On the read side, a downstream formatter sees the oldest stored word on `rd_data` in first-word-fall-through form. It removes that word by raising `rd_en`. It can also read an empty flag and the number of free slots.

A three-state controller tracks the fill condition:
- `ST_EMPTY`: no word is stored.
- `ST_OPEN`: the FIFO is partly filled.
- `ST_FULL`: every slot is in use.

The controller has these transitions:
- `T_FIRST_IN` (`ST_EMPTY` to `ST_OPEN`): a word is written into an empty FIFO.
- `T_FILL` (`ST_OPEN` to `ST_FULL`): a write without a read takes the last free slot.
- `T_DRAIN` (`ST_OPEN` to `ST_EMPTY`): a read without a write removes the last stored word.
- `T_RELIEF` (`ST_FULL` to `ST_OPEN`): a word is read out of a full FIFO.

When the depth is 1, `T_FIRST_IN` leads directly to `ST_FULL` and `T_RELIEF` leads directly to `ST_EMPTY`. Wait is high in `ST_FULL`. Empty is high in `ST_EMPTY`. Both come from the state register, so neither depends combinationally on the input strobe.

Top module: `chan_ingress_node`

## Requirements
- R1: A transferred word is kept only when `in_par` equals the XOR of all 32 bits of `in_data` (even parity over 33 bits).
- R2: A transfer happens on a rising edge where `in_valid`=1 and `in_wait`=0. Kept words appear on `rd_data` in the order they arrived.
- R3: `in_wait` is 1 exactly when the FIFO holds DEPTH words. It updates in the cycle after the edge that fills or relieves the FIFO.
- R4: A word offered while `in_wait`=1 is not stored and does not raise `parity_err`.
- R5: A transferred word with bad parity is discarded. `parity_err` is 1 for the single cycle that follows that edge.
- R6: In a cycle with `in_valid`=0, the values of `in_data` and `in_par` have no effect. Such a cycle never raises `parity_err`.
- R7: `rd_en`=1 with the FIFO not empty removes the oldest word at that edge. `rd_en`=1 with the FIFO empty has no effect.
- R8: `empty` is 1 exactly when no word is stored. `free_cnt` equals DEPTH minus the number of stored words.
- R9: While `rst_n`=0 at a rising edge, the node clears its contents. After that edge `empty`=1, `in_wait`=0, `parity_err`=0 and `free_cnt`=DEPTH.
- R10: A read and a good write on the same edge of a non-full, non-empty FIFO leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source word strobe |
| in_data | input | DATA_W | Source data word |
| in_par | input | 1 | Parity bit for the word (XOR of all data bits) |
| in_wait | output | 1 | Backpressure: high when no word can be taken |
| parity_err | output | 1 | One-cycle pulse after a word with bad parity is discarded |
| rd_en | input | 1 | Remove the oldest stored word |
| rd_data | output | DATA_W | Oldest stored word (valid when empty is low) |
| empty | output | 1 | No word stored |
| free_cnt | output | $clog2(DEPTH+1) | Number of free slots |

## Verification
The bench builds the node with DEPTH=8 and the default 32-bit data width. With a shallow FIFO, a random run with a low read rate keeps reaching `ST_FULL`. This exercises the stall path, offers while wait is high, and the `T_RELIEF` transition many times within a few thousand cycles. Directed sequences add the remaining corner cases:
- back-to-back bad words;
- reads while empty;
- idle cycles with garbage on the data lines;
- a reset taken while the FIFO holds data.

// File: rtl/cin_pkg.sv
package cin_pkg;

    // Fill condition of the ingress FIFO, owned by the controller
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_OPEN  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;

    // Width of a counter that must reach the value n inclusive
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Width of a pointer into n slots
    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cin_parity.sv
module cin_parity #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  logic              par_bit,
    output logic              par_ok
);
    // XOR folding tree built per bit position
    logic [DATA_W-1:0] fold;

    assign fold[0] = word[0];
    generate
        for (genvar g = 1; g < DATA_W; g++) begin : g_fold
            assign fold[g] = fold[g-1] ^ word[g];
        end
    endgenerate

    assign par_ok = (fold[DATA_W-1] == par_bit);

endmodule

// File: rtl/cin_fifo.sv
module cin_fifo
    import cin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        pop,
    output logic [DATA_W-1:0]           rdata,
    output logic [cnt_width(DEPTH)-1:0] count
);
    localparam int AW = ptr_width(DEPTH);
    localparam int CW = cnt_width(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign count = cnt_q;

endmodule

// File: rtl/cin_ctrl.sv
module cin_ctrl
    import cin_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        par_ok,
    input  logic                        rd_en,
    input  logic [cnt_width(DEPTH)-1:0] count,
    output logic                        push,
    output logic                        pop,
    output logic                        in_wait,
    output logic                        empty,
    output logic                        parity_err
);
    localparam int CW = cnt_width(DEPTH);
    localparam logic [CW-1:0] ONE_LEFT  = CW'(1);
    localparam logic [CW-1:0] NEAR_FULL = CW'(DEPTH - 1);

    fill_state_t state_q, state_d;
    logic        xfer, bad_xfer, err_q;

    // Transfer qualification: strobe high while not stalled
    assign xfer     = in_valid && (state_q != ST_FULL);
    assign push     = xfer && par_ok;
    assign bad_xfer = xfer && !par_ok;
    assign pop      = rd_en && (state_q != ST_EMPTY);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                // T_FIRST_IN
                if (push) state_d = (DEPTH == 1) ? ST_FULL : ST_OPEN;
            end
            ST_OPEN: begin
                if (push && !pop && count == NEAR_FULL)
                    state_d = ST_FULL;          // T_FILL
                else if (pop && !push && count == ONE_LEFT)
                    state_d = ST_EMPTY;         // T_DRAIN
            end
            ST_FULL: begin
                // T_RELIEF
                if (pop) state_d = (DEPTH == 1) ? ST_EMPTY : ST_OPEN;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Error pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_xfer;
    end

    // Outputs decoded from registered state
    always_comb begin
        in_wait    = 1'b0;
        empty      = 1'b0;
        parity_err = err_q;
        unique case (state_q)
            ST_EMPTY: empty   = 1'b1;
            ST_OPEN:  ;
            ST_FULL:  in_wait = 1'b1;
            default:  empty   = 1'b1;
        endcase
    end

endmodule

// File: rtl/chan_ingress_node.sv
module chan_ingress_node
    import cin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_par,
    output logic                        in_wait,
    output logic                        parity_err,
    input  logic                        rd_en,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        empty,
    output logic [cnt_width(DEPTH)-1:0] free_cnt
);
    localparam int CW = cnt_width(DEPTH);

    logic          par_ok, push, pop;
    logic [CW-1:0] count;

    cin_parity #(.DATA_W(DATA_W)) u_par (
        .word    (in_data),
        .par_bit (in_par),
        .par_ok  (par_ok)
    );

    cin_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .par_ok     (par_ok),
        .rd_en      (rd_en),
        .count      (count),
        .push       (push),
        .pop        (pop),
        .in_wait    (in_wait),
        .empty      (empty),
        .parity_err (parity_err)
    );

    cin_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (in_data),
        .pop   (pop),
        .rdata (rd_data),
        .count (count)
    );

    assign free_cnt = CW'(DEPTH) - count;

endmodule

// File: rtl/cin_checker.sv
module cin_checker
    import cin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [DATA_W-1:0]           in_data,
    input logic                        in_par,
    input logic                        in_wait,
    input logic                        parity_err,
    input logic                        rd_en,
    input logic [DATA_W-1:0]           rd_data,
    input logic                        empty,
    input logic [cnt_width(DEPTH)-1:0] free_cnt
);
    localparam int CW = cnt_width(DEPTH);

    // R3: the state-decoded stall agrees with the counter-derived free slots
    assert_wait_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait == (free_cnt == '0));

    // R8: the state-decoded empty agrees with the free slot count
    assert_empty_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (free_cnt == CW'(DEPTH)));

    // R4: a full FIFO stays full without a read, whatever is offered
    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !rd_en) |=> in_wait);

    // R5: an error pulse only follows a transferred word with bad parity
    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> $past(in_valid && !in_wait && (in_par != ^in_data)));

    // R6: idle cycles never raise the error output
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !parity_err);

    // R7: reading an empty FIFO with nothing arriving leaves it empty
    assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !in_valid) |=> empty);

    // R9: reset leaves the node empty, unstalled and quiet
    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (empty && !in_wait && !parity_err));

endmodule

bind chan_ingress_node cin_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/chan_ingress_node_tb.sv
module chan_ingress_node_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int DEPTH      = 8;
    localparam int CW         = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_par = 1'b0;
    logic              in_wait, parity_err, empty;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [CW-1:0]     free_cnt;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [DATA_W-1:0] mq[$];
    bit                merr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_ingress_node #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_par(in_par), .in_wait(in_wait), .parity_err(parity_err),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .free_cnt(free_cnt)
    );

    function automatic bit good_par(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model at the falling edge
    task automatic check_outputs(input string tag);
        bit mfull;
        mfull = (mq.size() == DEPTH);
        chk(in_wait === mfull, {tag, "/R3 wait"}, in_wait, mfull);
        chk(empty === (mq.size() == 0), {tag, "/R8 empty"}, empty, mq.size() == 0);
        chk(free_cnt === CW'(DEPTH - mq.size()), {tag, "/R8 free"}, free_cnt,
            DEPTH - mq.size());
        chk(parity_err === merr, {tag, "/R5 err"}, parity_err, merr);
        if (mq.size() > 0)
            chk(rd_data === mq[0], {tag, "/R2 data"}, rd_data, mq[0]);
    endtask

    // One cycle: check at negedge, drive, update the model, wait for the edge
    task automatic step(input bit v, input logic [DATA_W-1:0] d, input bit p,
                        input bit rd, input string tag);
        bit stall, xfer, pop;
        @(negedge clk);
        check_outputs(tag);
        in_valid = v; in_data = d; in_par = p; rd_en = rd;
        stall = (mq.size() == DEPTH);
        xfer  = v && !stall;
        pop   = rd && (mq.size() > 0);
        merr  = xfer && (p != good_par(d));
        if (pop) void'(mq.pop_front());
        if (xfer && p == good_par(d)) mq.push_back(d);
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; rd_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        merr = 1'b0;
        check_outputs("R9 reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] w;
        void'($urandom(32'd20240531));
        do_reset();

        // R1/R2: good words in order, then drained
        for (int i = 0; i < 4; i++) begin
            w = 32'hA5A5_0000 + i;
            step(1, w, good_par(w), 0, "R1 good");
        end
        for (int i = 0; i < 5; i++) step(0, '0, 0, 1, "R2 drain");

        // R7: read while empty has no effect
        step(0, '0, 0, 1, "R7 empty rd");
        step(0, '0, 0, 1, "R7 empty rd");

        // R5: back-to-back bad words dropped, pulses follow each
        step(1, 32'h0000_0001, 1'b0, 0, "R5 bad");
        step(1, 32'h0000_0003, 1'b1, 0, "R5 bad");
        step(0, '0, 0, 0, "R5 after");

        // R6: idle garbage never raises error or stores
        step(0, 32'hFFFF_FFFE, 1'b0, 0, "R6 idle");
        step(0, 32'h1234_5677, 1'b1, 0, "R6 idle");

        // R3/R4: fill to full, offer while stalled, then drain in order
        for (int i = 0; i < DEPTH; i++) begin
            w = 32'h5000_0000 + i;
            step(1, w, good_par(w), 0, "R3 fill");
        end
        step(1, 32'hDEAD_BEEF, good_par(32'hDEAD_BEEF), 0, "R4 stalled");
        step(1, 32'hDEAD_BEE0, ~good_par(32'hDEAD_BEE0), 0, "R4 stalled bad");
        step(1, 32'hDEAD_BEE1, good_par(32'hDEAD_BEE1), 1, "R4 relief");
        for (int i = 0; i < DEPTH + 1; i++) step(0, '0, 0, 1, "R4 drain");

        // R10: simultaneous read and write keeps the count
        step(1, 32'h0000_0011, good_par(32'h11), 0, "R10 seed");
        step(1, 32'h0000_0022, good_par(32'h22), 0, "R10 seed");
        for (int i = 0; i < 6; i++) begin
            w = 32'h7000_0000 + i;
            step(1, w, good_par(w), 1, "R10 rw");
        end

        // R9: reset taken with data stored
        do_reset();

        // Random traffic, two read rates
        for (int i = 0; i < 4000; i++) begin
            bit v, bad, rd;
            w   = $urandom;
            v   = ($urandom % 10) < 6;
            bad = ($urandom % 100) < 15;
            rd  = (i < 2000) ? (($urandom % 10) < 2) : (($urandom % 10) < 6);
            step(v, w, good_par(w) ^ bad, rd, "R1 rand");
        end
        step(0, '0, 0, 0, "end");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule